// File: doc/BRIEF.md
# Fly-by DMA Transfer Sequencer

This block sequences direct transfers between peripheral devices and memory for four independent channels. The data moves straight from the device to memory, or from memory to the device, over the system data bus. The sequencer only supplies the handshakes, the address and the read/write strobe pair, and it never holds the data. A channel that raises its request line, is not masked and is armed first obtains the bus from the host through a request/grant handshake. The sequencer then runs one or more transfer cycles. Each cycle drives the channel acknowledge, a 24-bit address and one memory strobe together with the opposite I/O strobe.

The channel configuration arrives on static inputs: base address, base count, page, mode, direction and autoinitialize. Each channel also has a load strobe that copies its base values into its working address and count and arms the channel. The programmed count is the transfer length minus one. Four modes decide when the bus goes back to the host: single, block, demand and cascade. With autoinitialize, a channel reloads itself at terminal count and stays armed.

Top module: `dma_flyby_seq`

## Requirements
- R1: A channel is serviceable only while its request is high, its mask bit is low and it is armed. Among serviceable channels, the lowest index wins. Any other requests are ignored while the bus is held.
- R2: In the cycle after an idle sequencer sees a serviceable request, bus_req goes high. No strobe, address or acknowledge is driven while bus_grant is low. bus_req returns low in the cycle after the last transfer of a tenure.
- R3: For a channel with to_mem=1, a transfer asserts io_rd and mem_wr together. With to_mem=0 it asserts mem_rd and io_wr together. addr_oe is high while either pair is driven.
- R4: chan_ack carries at most one bit, that of the channel in service, and only during its transfer or cascade tenure.
- R5: A transfer completes on a clock edge where xfer_rdy is high. While xfer_rdy is low, the strobes, the address and the acknowledge stay unchanged.
- R6: Each completed transfer adds one to the working address and subtracts one from the working count. xfer_end pulses during the transfer made with count 0, so a programmed count N gives N+1 transfers.
- R7: addr_out is {page, working address} with the page in bits 23..16. The working address wraps from 0xFFFF to 0x0000 and the page never changes.
- R8: Mode 0 (single) returns the bus after each transfer.
- R9: Mode 1 (block) keeps the bus until terminal count, whatever the request line does.
- R10: Mode 2 (demand) returns the bus after a transfer made while the request is low, and resumes when the request returns.
- R11: Mode 3 (cascade) drives only chan_ack. Strobes and addr_oe stay low and the tenure lasts until the request drops.
- R12: At terminal count, an autoinitialize channel reloads its base address and count and stays armed. Without autoinitialize the channel disarms until its next load.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| chan_req | input | 4 | Per-channel service request |
| chan_mask | input | 4 | Per-channel mask, 1 blocks service |
| chan_load | input | 4 | Copy base values into working state and arm |
| base_addr | input | 64 | Base address, 16 bits per channel, channel c at [16c+15:16c] |
| base_cnt | input | 64 | Base count (length minus one), 16 bits per channel |
| page | input | 32 | Page bits 23..16, 8 bits per channel |
| chan_mode | input | 8 | 2 bits per channel: 0 single, 1 block, 2 demand, 3 cascade |
| to_mem | input | 4 | 1: device to memory, 0: memory to device |
| auto_init | input | 4 | Reload at terminal count |
| bus_grant | input | 1 | Host grants the bus |
| xfer_rdy | input | 1 | Low stretches the current transfer |
| bus_req | output | 1 | Request for the bus |
| chan_ack | output | 4 | Per-channel acknowledge |
| addr_out | output | 24 | Transfer address {page, working address} |
| addr_oe | output | 1 | Address and strobes are driven |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| io_rd | output | 1 | I/O read strobe |
| io_wr | output | 1 | I/O write strobe |
| xfer_end | output | 1 | Terminal-count transfer in progress |

## Verification
On an autoinitialize channel, the terminal-count transfer, the reload of the working address and count, and the end of the tenure all fall on the same clock edge. The same edge decides whether the channel stays armed. The bench provokes this case by holding a block-mode autoinitialize request high across several tenures. It judges the result by the address of the first transfer after each reload and by one xfer_end per tenure. A demand-mode request that drops exactly as a transfer completes also brings the release decision and the step into one cycle. The bench's cycle-accurate model checks both cases on every clock.

// File: rtl/dma_pkg.sv
// Shared encodings for the fly-by DMA sequencer.
// Assumes: the mode code values are visible at the top-level ports.
package dma_pkg;
    typedef enum logic [1:0] {
        MODE_SINGLE  = 2'd0,
        MODE_BLOCK   = 2'd1,
        MODE_DEMAND  = 2'd2,
        MODE_CASCADE = 2'd3
    } xfer_mode_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_HOLD = 2'd1,
        ST_XFER = 2'd2,
        ST_CASC = 2'd3
    } seq_state_e;
endpackage

// File: rtl/dma_prio_arb.sv
// Fixed-priority picker: the lowest-index active request wins.
// Assumes: NCH >= 2. The output is meaningful only while req_any is high.
module dma_prio_arb #(
    parameter int NCH = 4,
    localparam int IW = $clog2(NCH)
) (
    input  logic [NCH-1:0] req,
    output logic           req_any,
    output logic [IW-1:0]  win_idx
);
    logic [NCH-1:0] lower_busy;
    logic [NCH-1:0] grant;

    generate
        for (genvar i = 0; i < NCH; i++) begin : g_chain
            if (i == 0) begin : g_first
                assign lower_busy[i] = 1'b0;
            end else begin : g_rest
                assign lower_busy[i] = lower_busy[i-1] | req[i-1];
            end
            assign grant[i] = req[i] & ~lower_busy[i];
        end
    endgenerate

    assign req_any = |req;

    // Encode the one-hot grant into an index.
    always_comb begin
        win_idx = '0;
        for (int i = 0; i < NCH; i++) begin
            if (grant[i]) win_idx = win_idx | IW'(i);
        end
    end
endmodule

// File: rtl/dma_chan_ctx.sv
// Working state of one channel: current address, current count and armed flag.
// Assumes: a load takes priority over a step in the same cycle. The address
// wraps inside AW bits and never carries into the page.
module dma_chan_ctx #(
    parameter int AW = 16,
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          step,
    input  logic          autoinit,
    input  logic [AW-1:0] base_addr,
    input  logic [CW-1:0] base_cnt,
    output logic [AW-1:0] cur_addr,
    output logic          armed,
    output logic          tc
);
    logic [CW-1:0] cur_cnt;

    assign tc = (cur_cnt == '0);

    // Load from base, advance on each transfer, reload or disarm at terminal count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_addr <= '0;
            cur_cnt  <= '0;
            armed    <= 1'b0;
        end else if (load) begin
            cur_addr <= base_addr;
            cur_cnt  <= base_cnt;
            armed    <= 1'b1;
        end else if (step) begin
            if (tc && autoinit) begin
                cur_addr <= base_addr;
                cur_cnt  <= base_cnt;
            end else begin
                cur_addr <= cur_addr + 1'b1;
                cur_cnt  <= cur_cnt - 1'b1;
                if (tc) armed <= 1'b0;
            end
        end
    end

    // R7
    addr_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load && !(tc && autoinit) && cur_addr == '1) |=> (cur_addr == '0));
    // R6
    cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load && !tc) |=> (cur_cnt == $past(cur_cnt) - 1'b1));
    // R12
    reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load && tc && autoinit) |=>
        (cur_addr == $past(base_addr) && cur_cnt == $past(base_cnt) && armed));
    // R12
    disarm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load && tc && !autoinit) |=> !armed);
endmodule

// File: rtl/dma_seq_fsm.sv
// Bus tenure sequencer: idle, wait for grant, transfer, or cascade pass-through.
// Assumes: the inputs for the selected channel are already muxed by sel. A
// transfer completes on each edge with rdy high.
module dma_seq_fsm
    import dma_pkg::*;
#(
    parameter int NCH = 4,
    localparam int IW = $clog2(NCH)
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        svc_any,
    input  logic [IW-1:0] svc_idx,
    input  logic        grant,
    input  logic        rdy,
    input  logic        req_sel,
    input  logic        tc_sel,
    input  xfer_mode_e  mode_sel,
    output seq_state_e  state,
    output logic [IW-1:0] sel,
    output logic        step
);
    logic release_now;

    assign step = (state == ST_XFER) && rdy;

    // Decide whether the completing transfer ends the tenure.
    always_comb begin
        release_now = tc_sel;
        unique case (mode_sel)
            MODE_SINGLE: release_now = 1'b1;
            MODE_DEMAND: release_now = tc_sel | ~req_sel;
            default:     release_now = tc_sel;
        endcase
    end

    // State and selected-channel register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            sel   <= '0;
        end else begin
            unique case (state)
                ST_IDLE: if (svc_any) begin
                    state <= ST_HOLD;
                    sel   <= svc_idx;
                end
                ST_HOLD: if (grant) begin
                    state <= (mode_sel == MODE_CASCADE) ? ST_CASC : ST_XFER;
                end
                ST_XFER: if (rdy && release_now) state <= ST_IDLE;
                ST_CASC: if (!req_sel) state <= ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R5
    rdy_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_XFER && !rdy) |=> (state == ST_XFER && $stable(sel)));
    // R9
    block_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_XFER && rdy && mode_sel == MODE_BLOCK && !tc_sel) |=> (state == ST_XFER));
    // R2
    wait_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HOLD && !grant) |=> (state == ST_HOLD));
    // R8
    single_rel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_XFER && rdy && mode_sel == MODE_SINGLE) |=> (state == ST_IDLE));
    // R11
    casc_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_CASC && req_sel) |=> (state == ST_CASC));
endmodule

// File: rtl/dma_flyby_seq.sv
// Fly-by DMA sequencer top: arbitration, per-channel working state, and bus
// outputs for NCH channels. Data never passes through this block.
// Assumes: configuration inputs stay stable while their channel is in service.
module dma_flyby_seq
    import dma_pkg::*;
#(
    parameter int NCH = 4,
    parameter int AW  = 16,
    parameter int PW  = 8,
    localparam int IW = $clog2(NCH),
    localparam int FW = PW + AW
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NCH-1:0]    chan_req,
    input  logic [NCH-1:0]    chan_mask,
    input  logic [NCH-1:0]    chan_load,
    input  logic [NCH*AW-1:0] base_addr,
    input  logic [NCH*AW-1:0] base_cnt,
    input  logic [NCH*PW-1:0] page,
    input  logic [2*NCH-1:0]  chan_mode,
    input  logic [NCH-1:0]    to_mem,
    input  logic [NCH-1:0]    auto_init,
    input  logic              bus_grant,
    input  logic              xfer_rdy,
    output logic              bus_req,
    output logic [NCH-1:0]    chan_ack,
    output logic [FW-1:0]     addr_out,
    output logic              addr_oe,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic              io_rd,
    output logic              io_wr,
    output logic              xfer_end
);
    logic [AW-1:0] addr_a [NCH];
    logic [PW-1:0] page_a [NCH];
    xfer_mode_e    mode_a [NCH];
    logic [NCH-1:0] armed_v, tc_v, svc_v;
    logic          svc_any, step, bus_on;
    logic [IW-1:0] svc_idx, sel;
    seq_state_e    state;

    generate
        for (genvar c = 0; c < NCH; c++) begin : g_ch
            assign page_a[c] = page[c*PW +: PW];
            assign mode_a[c] = xfer_mode_e'(chan_mode[c*2 +: 2]);
            assign svc_v[c]  = chan_req[c] & ~chan_mask[c] & armed_v[c];
            assign chan_ack[c] = ((state == ST_XFER) || (state == ST_CASC)) && (sel == IW'(c));

            dma_chan_ctx #(.AW(AW), .CW(AW)) u_ctx (
                .clk       (clk),
                .rst_n     (rst_n),
                .load      (chan_load[c]),
                .step      (step && (sel == IW'(c))),
                .autoinit  (auto_init[c]),
                .base_addr (base_addr[c*AW +: AW]),
                .base_cnt  (base_cnt[c*AW +: AW]),
                .cur_addr  (addr_a[c]),
                .armed     (armed_v[c]),
                .tc        (tc_v[c])
            );
        end
    endgenerate

    dma_prio_arb #(.NCH(NCH)) u_arb (
        .req     (svc_v),
        .req_any (svc_any),
        .win_idx (svc_idx)
    );

    dma_seq_fsm #(.NCH(NCH)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .svc_any  (svc_any),
        .svc_idx  (svc_idx),
        .grant    (bus_grant),
        .rdy      (xfer_rdy),
        .req_sel  (chan_req[sel]),
        .tc_sel   (tc_v[sel]),
        .mode_sel (mode_a[sel]),
        .state    (state),
        .sel      (sel),
        .step     (step)
    );

    assign bus_req  = (state != ST_IDLE);
    assign bus_on   = (state == ST_XFER);
    assign addr_oe  = bus_on;
    assign addr_out = bus_on ? {page_a[sel], addr_a[sel]} : '0;
    assign mem_wr   = bus_on &  to_mem[sel];
    assign io_rd    = bus_on &  to_mem[sel];
    assign mem_rd   = bus_on & ~to_mem[sel];
    assign io_wr    = bus_on & ~to_mem[sel];
    assign xfer_end = step & tc_v[sel];

    // R4
    ack_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(chan_ack));
    // R3
    strobe_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr || io_rd) |-> (mem_wr && io_rd && !mem_rd && !io_wr && addr_oe));
    // R2
    strobe_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd || mem_wr || io_rd || io_wr) |-> (bus_req && $countones(chan_ack) == 1));
    // R11
    casc_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (chan_ack != '0 && !addr_oe) |-> !(mem_rd || mem_wr || io_rd || io_wr));
    // R6
    end_in_xfer_chk: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_end |-> (addr_oe && xfer_rdy));
endmodule

// File: tb/tb_dma_flyby_seq.sv
// Bench: behavioural cycle model compared every clock, plus directed scenarios.
module tb_dma_flyby_seq;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [3:0]  chan_req = '0, chan_mask = '0, chan_load = '0, to_mem = '0, auto_init = '0;
    logic [63:0] base_addr = '0, base_cnt = '0;
    logic [31:0] page = '0;
    logic [7:0]  chan_mode = '0;
    logic        bus_grant = 1'b0, xfer_rdy = 1'b1, ack_en = 1'b1;
    logic        bus_req, addr_oe, mem_rd, mem_wr, io_rd, io_wr, xfer_end;
    logic [3:0]  chan_ack;
    logic [23:0] addr_out;

    always #10 clk = ~clk;

    dma_flyby_seq dut (
        .clk(clk), .rst_n(rst_n), .chan_req(chan_req), .chan_mask(chan_mask),
        .chan_load(chan_load), .base_addr(base_addr), .base_cnt(base_cnt), .page(page),
        .chan_mode(chan_mode), .to_mem(to_mem), .auto_init(auto_init),
        .bus_grant(bus_grant), .xfer_rdy(xfer_rdy), .bus_req(bus_req), .chan_ack(chan_ack),
        .addr_out(addr_out), .addr_oe(addr_oe), .mem_rd(mem_rd), .mem_wr(mem_wr),
        .io_rd(io_rd), .io_wr(io_wr), .xfer_end(xfer_end)
    );

    // Host side: grants the bus right after it is requested, when enabled.
    initial forever begin
        @(posedge clk); #1;
        bus_grant = ack_en && bus_req;
    end

    // ---------------- reference model ----------------
    int m_state, m_sel, seen_rst;
    int m_addr [4], m_cnt [4], m_arm [4];

    function automatic int md(int c);
        return int'(chan_mode[c*2 +: 2]);
    endfunction

    initial seen_rst = 0;

    always @(posedge clk) begin
        int nst, nsel, mode;
        bit tc;
        if (!rst_n) begin
            seen_rst = 1; m_state = 0; m_sel = 0;
            for (int c = 0; c < 4; c++) begin m_addr[c] = 0; m_cnt[c] = 0; m_arm[c] = 0; end
        end else begin
            nst = m_state; nsel = m_sel;
            case (m_state)
                0: for (int c = 3; c >= 0; c--)
                       if (chan_req[c] && !chan_mask[c] && m_arm[c] != 0) begin nst = 1; nsel = c; end
                1: if (bus_grant) nst = (md(m_sel) == 3) ? 3 : 2;
                2: if (xfer_rdy) begin
                       mode = md(m_sel);
                       tc = (m_cnt[m_sel] == 0);
                       if (tc && auto_init[m_sel]) begin
                           m_addr[m_sel] = int'(base_addr[m_sel*16 +: 16]);
                           m_cnt[m_sel]  = int'(base_cnt[m_sel*16 +: 16]);
                       end else begin
                           m_addr[m_sel] = (m_addr[m_sel] + 1) & 'hFFFF;
                           m_cnt[m_sel]  = (m_cnt[m_sel] - 1) & 'hFFFF;
                           if (tc) m_arm[m_sel] = 0;
                       end
                       if (tc || mode == 0 || (mode == 2 && !chan_req[m_sel])) nst = 0;
                   end
                default: if (!chan_req[m_sel]) nst = 0;
            endcase
            for (int c = 0; c < 4; c++) if (chan_load[c]) begin
                m_addr[c] = int'(base_addr[c*16 +: 16]);
                m_cnt[c]  = int'(base_cnt[c*16 +: 16]);
                m_arm[c]  = 1;
            end
            m_state = nst; m_sel = nsel;
        end
    end

    // ---------------- monitor: compare every clock, log transfers ----------------
    int mchecks = 0, mfail = 0, xfers = 0, eops = 0, holds = 0;
    logic prev_req = 1'b0;
    logic [23:0] alog [8];
    logic [3:0]  dlog [8];
    int bx = 0;

    task automatic mchk(string tag, logic [31:0] a, logic [31:0] e);
        mchecks++;
        if (a !== e) begin
            mfail++;
            $display("FAIL %s model mismatch at %0t: actual=%h expected=%h", tag, $time, a, e);
        end
    endtask

    always @(negedge clk) begin
        logic bus, tm;
        logic [4:0] es;
        if (rst_n && seen_rst != 0) begin
            bus = (m_state == 2);
            tm  = to_mem[m_sel];
            es  = bus ? (tm ? 5'b01101 : 5'b10011) : 5'b00000;
            mchk("R2", {31'd0, bus_req}, {31'd0, m_state != 0});
            mchk("R4", {28'd0, chan_ack}, (m_state >= 2) ? (32'd1 << m_sel) : 32'd0);
            mchk("R3", {27'd0, mem_rd, mem_wr, io_rd, io_wr, addr_oe}, {27'd0, es});
            mchk("R7", {8'd0, addr_out},
                 bus ? {8'd0, page[m_sel*8 +: 8], m_addr[m_sel][15:0]} : 32'd0);
            mchk("R6", {31'd0, xfer_end}, {31'd0, bus && xfer_rdy && m_cnt[m_sel] == 0});
        end
        if ((mem_rd || mem_wr) && xfer_rdy) begin
            if (xfers - bx < 8) begin
                alog[xfers - bx] = addr_out;
                dlog[xfers - bx] = chan_ack;
            end
            xfers++;
        end
        if (xfer_end) eops++;
        if (bus_req && !prev_req) holds++;
        prev_req = bus_req;
    end

    // ---------------- directed scenarios ----------------
    int dchecks = 0, dfail = 0;
    int be = 0, bh = 0;

    task automatic dchk(string tag, logic [31:0] a, logic [31:0] e);
        dchecks++;
        if (a !== e) begin
            dfail++;
            $display("FAIL %s at %0t: actual=%h expected=%h", tag, $time, a, e);
        end
    endtask

    task automatic cyc(int n);
        repeat (n) begin @(posedge clk); #2; end
    endtask

    task automatic cfg(int c, logic [15:0] a, logic [15:0] n, logic [7:0] pg,
                       logic [1:0] mo, logic tm, logic ai);
        base_addr[c*16 +: 16] = a;
        base_cnt[c*16 +: 16]  = n;
        page[c*8 +: 8]        = pg;
        chan_mode[c*2 +: 2]   = mo;
        to_mem[c]             = tm;
        auto_init[c]          = ai;
    endtask

    task automatic pulse_load(logic [3:0] which);
        chan_load = which; cyc(1); chan_load = '0;
    endtask

    task automatic clr;
        bx = xfers; be = eops; bh = holds;
    endtask

    initial begin
        cyc(3);
        rst_n = 1'b1;
        cyc(1);
        // Reset state: idle, nothing driven
        dchk("R2 reset bus_req", {31'd0, bus_req}, 32'd0);
        dchk("R4 reset ack", {28'd0, chan_ack}, 32'd0);
        dchk("R3 reset strobes", {28'd0, mem_rd, mem_wr, io_rd, io_wr}, 32'd0);

        // Single mode, grant held off at first; channel disarms at terminal count
        cfg(2, 16'h3456, 16'd2, 8'h12, 2'd0, 1'b1, 1'b0);
        pulse_load(4'b0100);
        clr; ack_en = 1'b0; chan_req[2] = 1'b1;
        cyc(6);
        dchk("R2 waits for grant", {31'd0, bus_req}, 32'd1);
        dchk("R2 no transfer before grant", xfers - bx, 0);
        ack_en = 1'b1;
        cyc(30);
        dchk("R8 transfer count", xfers - bx, 3);
        dchk("R8 one tenure per transfer", holds - bh, 3);
        dchk("R6 one end pulse", eops - be, 1);
        dchk("R7 first address", {8'd0, alog[0]}, 32'h123456);
        dchk("R12 disarmed despite request", {31'd0, bus_req}, 32'd0);
        chan_req[2] = 1'b0;

        // Block mode with stretched transfers and a one-cycle request pulse
        cfg(1, 16'h0100, 16'd3, 8'h01, 2'd1, 1'b0, 1'b0);
        pulse_load(4'b0010);
        clr; xfer_rdy = 1'b0; chan_req[1] = 1'b1;
        cyc(1); chan_req[1] = 1'b0;
        cyc(8);
        dchk("R5 stall holds strobes", {30'd0, mem_rd, io_wr}, 32'd3);
        dchk("R5 no progress while not ready", xfers - bx, 0);
        xfer_rdy = 1'b1; cyc(1); xfer_rdy = 1'b0; cyc(3);
        dchk("R5 one transfer per ready edge", xfers - bx, 1);
        xfer_rdy = 1'b1;
        cyc(10);
        dchk("R9 block completes without request", xfers - bx, 4);
        dchk("R9 single tenure", holds - bh, 1);
        dchk("R6 end after count+1", eops - be, 1);

        // Demand mode: pause when request drops, resume when it returns
        cfg(3, 16'h2000, 16'd5, 8'h20, 2'd2, 1'b1, 1'b0);
        pulse_load(4'b1000);
        clr; chan_req[3] = 1'b1;
        for (int k = 0; k < 40 && (xfers - bx) < 2; k++) cyc(1);
        chan_req[3] = 1'b0;
        cyc(5);
        dchk("R10 paused", {31'd0, bus_req}, 32'd0);
        dchk("R10 transfers before pause", xfers - bx, 3);
        chan_req[3] = 1'b1;
        cyc(20);
        dchk("R10 resumed to completion", xfers - bx, 6);
        dchk("R10 two tenures", holds - bh, 2);
        chan_req[3] = 1'b0;

        // Mask and fixed priority
        cfg(0, 16'h0010, 16'd0, 8'h00, 2'd0, 1'b1, 1'b0);
        cfg(2, 16'h0500, 16'd0, 8'h05, 2'd0, 1'b0, 1'b0);
        chan_mask[0] = 1'b1;
        pulse_load(4'b0101);
        clr; chan_req = 4'b0101;
        cyc(10);
        dchk("R1 masked channel skipped", {28'd0, dlog[0]}, 32'h4);
        dchk("R1 one transfer", xfers - bx, 1);
        chan_req[2] = 1'b0;
        pulse_load(4'b0100);
        clr; chan_mask[0] = 1'b0; chan_req[2] = 1'b1;
        cyc(15);
        dchk("R1 channel 0 first", {28'd0, dlog[0]}, 32'h1);
        dchk("R1 channel 2 next", {28'd0, dlog[1]}, 32'h4);
        chan_req = '0;

        // Cascade pass-through
        cfg(1, 16'h0000, 16'd0, 8'h00, 2'd3, 1'b0, 1'b0);
        pulse_load(4'b0010);
        chan_req[1] = 1'b1;
        cyc(6);
        dchk("R11 only ack driven", {26'd0, chan_ack, addr_oe, mem_rd | mem_wr | io_rd | io_wr}, 32'h8);
        dchk("R11 bus held", {31'd0, bus_req}, 32'd1);
        chan_req[1] = 1'b0;
        cyc(3);
        dchk("R11 released on drop", {27'd0, bus_req, chan_ack}, 32'd0);

        // Address wrap inside the page
        cfg(0, 16'hFFFE, 16'd3, 8'h7F, 2'd1, 1'b1, 1'b0);
        pulse_load(4'b0001);
        clr; chan_req[0] = 1'b1; cyc(1); chan_req[0] = 1'b0;
        cyc(12);
        dchk("R7 before wrap", {8'd0, alog[1]}, 32'h7FFFFF);
        dchk("R7 wrap keeps page", {8'd0, alog[2]}, 32'h7F0000);
        dchk("R7 after wrap", {8'd0, alog[3]}, 32'h7F0001);

        // Autoinitialize: reload and stay armed
        cfg(3, 16'h4000, 16'd1, 8'h40, 2'd1, 1'b0, 1'b1);
        pulse_load(4'b1000);
        clr; chan_req[3] = 1'b1;
        cyc(20);
        dchk("R12 reload address", {8'd0, alog[2]}, 32'h404000);
        dchk("R12 repeated end pulses", {31'd0, (eops - be) >= 2}, 32'd1);
        chan_req[3] = 1'b0;
        cyc(4);

        $display("TB_RESULT checks=%0d failures=%0d", dchecks + mchecks, dfail + mfail);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        $display("FAIL watchdog: run did not finish");
        $display("TB_RESULT checks=%0d failures=%0d", dchecks + mchecks + 1, dfail + mfail + 1);
        $finish;
    end
endmodule